// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block sits between a host and a serial EEPROM that uses 16-bit addresses. The host issues one request at a time: a direction (read or page write), a start address and a byte count. Data bytes pass through valid/ready handshakes. The block turns each request into the SPI frames the memory expects. It drives the serial clock, the outgoing data line and an active-low chip select, and it samples the incoming data line.

Every write is handled in three steps. The block first sends the latch-enable instruction in a frame of its own. It then sends the write frame. After that it reads the status register again and again until the busy bit clears, or until a poll limit is reached. A write burst that would run past the end of a 64-byte page is refused before any bus activity, and so is any request with a count of zero. A read is sent as one long frame and returns any number of bytes.

Top module: `spi_eeprom_seq`

## Requirements
- R1: The serial link uses mode 0. SCK idles low. Each byte goes out most significant bit first, MOSI is steady at every rising SCK edge, and MISO is sampled on the rising edge. Within a byte, consecutive rising SCK edges are DIV system clocks apart (DIV even, default 4).
- R2: `spi_cs_n` is low for exactly one instruction frame. Between two frames it stays high for at least 2*DIV system clocks. SCK is low whenever `spi_cs_n` is high.
- R3: Every accepted write starts with a frame that holds only the byte 0x06.
- R4: The write frame carries 0x02, then the address high byte, then the address low byte, then exactly `cmd_len` data bytes in the order the host handed them over on the `wr_valid`/`wr_ready` handshake.
- R5: A write whose offset (`cmd_addr[5:0]`) plus `cmd_len` exceeds 64 is refused, and so is any request with `cmd_len` of 0. For a refused request, `done` and `err_req` are high together one cycle after acceptance, and no frame is sent. A write with offset plus count equal to 64 is accepted.
- R6: After the write frame, the block sends status frames (0x05 followed by one fill byte 0x00). It keeps doing so until bit 0 of the returned status byte is 0, and raises `done` only after that.
- R7: If POLL_MAX status frames in a row return bit 0 as 1, the block stops polling and pulses `done` with `err_timeout` high. A clear status read on the last allowed poll finishes without a timeout.
- R8: A read sends 0x03, the address high byte, the address low byte and then `cmd_len` fill bytes of 0x00, all in one frame. The bytes returned on MISO come out on `rd_data` in order. `rd_data` holds steady while `rd_valid` is high and `rd_ready` is low.
- R9: `cmd_ready` is high only while the block is idle. `busy` is high from acceptance until `done`. `done` is a single-cycle pulse. After reset the block is idle with `spi_cs_n` high and SCK low.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Request accepted this cycle when valid |
| cmd_write | input | 1 | 1 = page write, 0 = read |
| cmd_addr | input | 16 | Start address in the memory |
| cmd_len | input | LEN_W | Byte count |
| wr_data | input | 8 | Write byte from the host |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Write byte taken this cycle when valid |
| rd_data | output | 8 | Read byte to the host |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Host takes the read byte |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err_req | output | 1 | With `done`: request refused |
| err_timeout | output | 1 | With `done`: busy poll limit reached |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The poll-limit counter and the status-bit test are both decided on the same returned status byte. On the POLL_MAX-th poll, either a clear bit or the end of the limit can end the request. The bench's memory model stays busy for exactly POLL_MAX-1 polls in one run and for exactly POLL_MAX polls in the next. The first run must finish without `err_timeout` after POLL_MAX status frames. The second must stop with `err_timeout` after POLL_MAX frames. The same frame-by-frame comparison also covers the case where a host stall on `rd_ready` lands while the read frame is still open.

// File: rtl/eep_seq_pkg.sv
package eep_seq_pkg;

    localparam logic [7:0] OP_LATCH_ON = 8'h06;
    localparam logic [7:0] OP_PROGRAM  = 8'h02;
    localparam logic [7:0] OP_FETCH    = 8'h03;
    localparam logic [7:0] OP_STATUS   = 8'h05;
    localparam logic [7:0] FILL_BYTE   = 8'h00;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_GAP,
        PH_WEN,
        PH_WCMD,
        PH_RCMD,
        PH_ADDR_H,
        PH_ADDR_L,
        PH_WDATA,
        PH_RDATA,
        PH_RHAND,
        PH_POLL_CMD,
        PH_POLL_STAT,
        PH_FIN
    } phase_t;

    typedef struct packed {
        logic        is_wr;
        logic [15:0] addr;
    } req_t;

    // Phases during which chip select is held low.
    function automatic logic in_frame(input phase_t p);
        return p inside {PH_WEN, PH_WCMD, PH_RCMD, PH_ADDR_H, PH_ADDR_L,
                         PH_WDATA, PH_RDATA, PH_RHAND, PH_POLL_CMD, PH_POLL_STAT};
    endfunction

    // A request is legal when it moves at least one byte and, for a write,
    // the burst stays inside one page (page size a power of two).
    function automatic logic burst_ok(input logic        is_wr,
                                      input logic [15:0] addr,
                                      input logic [31:0] len,
                                      input logic [31:0] page_bytes);
        logic [31:0] off;
        off = {16'd0, addr} & (page_bytes - 32'd1);
        if (len == 32'd0) return 1'b0;
        if (!is_wr)       return 1'b1;
        return (off + len) <= page_bytes;
    endfunction

endpackage

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int HALF = DIV / 2;
    localparam int HCW  = (HALF > 1) ? $clog2(HALF) : 1;

    logic [HCW-1:0] hcnt;
    logic [2:0]     bit_idx;
    logic [7:0]     tx_sh;
    logic           edge_now;

    assign edge_now = busy && (hcnt == HCW'(HALF - 1));
    assign mosi     = tx_sh[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck     <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            hcnt    <= '0;
            bit_idx <= '0;
            tx_sh   <= '0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy    <= 1'b1;
                tx_sh   <= tx_byte;
                hcnt    <= '0;
                bit_idx <= '0;
                sck     <= 1'b0;
            end else if (busy) begin
                if (edge_now) begin
                    hcnt <= '0;
                    if (!sck) begin
                        sck     <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bit_idx == 3'd7) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 3'd1;
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                        end
                    end
                end else begin
                    hcnt <= hcnt + HCW'(1);
                end
            end
        end
    end

    // R1: a byte is only launched into an idle shifter
    p_start_idle_r1: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
    // R1: a byte ends with the clock back at its low idle level
    p_done_low_r1: assert property (@(posedge clk) disable iff (rst)
        done |-> !sck);
    // R1: MOSI does not move while SCK is high
    p_mosi_steady_r1: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi));

endmodule

// File: rtl/eep_cmd_fsm.sv
module eep_cmd_fsm
    import eep_seq_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 64,
    parameter int POLL_MAX   = 65535
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_write,
    input  logic [15:0]      cmd_addr,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic             busy,
    output logic             done,
    output logic             err_req,
    output logic             err_timeout,
    output logic             cs_n,
    output logic             eng_start,
    output logic [7:0]       eng_tx,
    input  logic             eng_done,
    input  logic [7:0]       eng_rx
);
    localparam int GAP_CYC = 2 * DIV;
    localparam int GCW     = $clog2(GAP_CYC + 1);
    localparam int PCW     = $clog2(POLL_MAX + 1);

    phase_t           ph, gap_next;
    req_t             req;
    logic             inflight;
    logic [GCW-1:0]   gap_cnt;
    logic [LEN_W-1:0] remain;
    logic [PCW-1:0]   pcnt;
    logic [7:0]       rd_q;
    logic             fl_req, fl_to;
    logic             req_ok;

    always_comb begin
        req_ok = burst_ok(cmd_write, cmd_addr, 32'(cmd_len), 32'(PAGE_BYTES));
    end

    assign cmd_ready   = (ph == PH_IDLE);
    assign busy        = (ph != PH_IDLE);
    assign done        = (ph == PH_FIN);
    assign err_req     = done && fl_req;
    assign err_timeout = done && fl_to;
    assign cs_n        = !in_frame(ph);
    assign wr_ready    = (ph == PH_WDATA) && !inflight;
    assign rd_valid    = (ph == PH_RHAND);
    assign rd_data     = rd_q;

    always_comb begin
        eng_start = 1'b0;
        eng_tx    = FILL_BYTE;
        case (ph)
            PH_WEN:       begin eng_tx = OP_LATCH_ON;     eng_start = !inflight; end
            PH_WCMD:      begin eng_tx = OP_PROGRAM;      eng_start = !inflight; end
            PH_RCMD:      begin eng_tx = OP_FETCH;        eng_start = !inflight; end
            PH_ADDR_H:    begin eng_tx = req.addr[15:8];  eng_start = !inflight; end
            PH_ADDR_L:    begin eng_tx = req.addr[7:0];   eng_start = !inflight; end
            PH_WDATA:     begin eng_tx = wr_data;         eng_start = !inflight && wr_valid; end
            PH_RDATA:     begin eng_tx = FILL_BYTE;       eng_start = !inflight; end
            PH_POLL_CMD:  begin eng_tx = OP_STATUS;       eng_start = !inflight; end
            PH_POLL_STAT: begin eng_tx = FILL_BYTE;       eng_start = !inflight; end
            default:      begin eng_tx = FILL_BYTE;       eng_start = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            gap_next <= PH_IDLE;
            req      <= '0;
            inflight <= 1'b0;
            gap_cnt  <= '0;
            remain   <= '0;
            pcnt     <= '0;
            rd_q     <= '0;
            fl_req   <= 1'b0;
            fl_to    <= 1'b0;
        end else begin
            if (eng_start)     inflight <= 1'b1;
            else if (eng_done) inflight <= 1'b0;

            case (ph)
                PH_IDLE: begin
                    fl_req <= 1'b0;
                    fl_to  <= 1'b0;
                    pcnt   <= '0;
                    if (cmd_valid) begin
                        req.is_wr <= cmd_write;
                        req.addr  <= cmd_addr;
                        remain    <= cmd_len;
                        if (!req_ok) begin
                            fl_req <= 1'b1;
                            ph     <= PH_FIN;
                        end else begin
                            gap_next <= cmd_write ? PH_WEN : PH_RCMD;
                            gap_cnt  <= '0;
                            ph       <= PH_GAP;
                        end
                    end
                end
                PH_GAP: begin
                    if (gap_cnt == GCW'(GAP_CYC - 1)) ph <= gap_next;
                    else gap_cnt <= gap_cnt + GCW'(1);
                end
                PH_WEN: if (eng_done) begin
                    gap_next <= PH_WCMD;
                    gap_cnt  <= '0;
                    ph       <= PH_GAP;
                end
                PH_WCMD, PH_RCMD: if (eng_done) ph <= PH_ADDR_H;
                PH_ADDR_H:        if (eng_done) ph <= PH_ADDR_L;
                PH_ADDR_L:        if (eng_done) ph <= req.is_wr ? PH_WDATA : PH_RDATA;
                PH_WDATA: if (eng_done) begin
                    if (remain == LEN_W'(1)) begin
                        gap_next <= PH_POLL_CMD;
                        gap_cnt  <= '0;
                        ph       <= PH_GAP;
                    end else begin
                        remain <= remain - LEN_W'(1);
                    end
                end
                PH_RDATA: if (eng_done) begin
                    rd_q <= eng_rx;
                    ph   <= PH_RHAND;
                end
                PH_RHAND: if (rd_ready) begin
                    if (remain == LEN_W'(1)) ph <= PH_FIN;
                    else begin
                        remain <= remain - LEN_W'(1);
                        ph     <= PH_RDATA;
                    end
                end
                PH_POLL_CMD: if (eng_done) ph <= PH_POLL_STAT;
                PH_POLL_STAT: if (eng_done) begin
                    if (!eng_rx[0]) begin
                        ph <= PH_FIN;
                    end else if (pcnt == PCW'(POLL_MAX - 1)) begin
                        fl_to <= 1'b1;
                        ph    <= PH_FIN;
                    end else begin
                        pcnt     <= pcnt + PCW'(1);
                        gap_next <= PH_POLL_CMD;
                        gap_cnt  <= '0;
                        ph       <= PH_GAP;
                    end
                end
                PH_FIN:  ph <= PH_IDLE;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // R5: a refused request ends at once, with the bus left alone
    p_reject_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && !req_ok) |=> (done && err_req && cs_n));
    // R9: done lasts one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R9: busy from acceptance onward
    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> busy);
    // R8: a held read byte does not change
    p_rd_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
    // R4: write bytes are taken only inside an open frame
    p_wr_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> !cs_n);
    // R7: a timeout is only reported with done
    p_timeout_with_done_r7: assert property (@(posedge clk) disable iff (rst)
        err_timeout |-> done);

endmodule

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq
    import eep_seq_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 64,
    parameter int POLL_MAX   = 65535
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_write,
    input  logic [15:0]      cmd_addr,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic             busy,
    output logic             done,
    output logic             err_req,
    output logic             err_timeout,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             spi_cs_n
);
    logic       eng_start, eng_busy, eng_done;
    logic [7:0] eng_tx, eng_rx;

    eep_cmd_fsm #(
        .DIV(DIV), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .POLL_MAX(POLL_MAX)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .busy(busy), .done(done), .err_req(err_req), .err_timeout(err_timeout),
        .cs_n(spi_cs_n),
        .eng_start(eng_start), .eng_tx(eng_tx), .eng_done(eng_done), .eng_rx(eng_rx)
    );

    spi_bit_engine #(.DIV(DIV)) u_eng (
        .clk(clk), .rst(rst), .start(eng_start), .tx_byte(eng_tx),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
        .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx)
    );

    // R2: the clock never runs while the memory is deselected
    p_sck_low_deselected_r2: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);
    // R2: a byte in flight keeps chip select low
    p_cs_held_in_byte_r2: assert property (@(posedge clk) disable iff (rst)
        eng_busy |-> !spi_cs_n);

endmodule

// File: tb/spi_eeprom_seq_tb.sv
`timescale 1ns/1ps
module spi_eeprom_seq_tb;
    localparam int DIV      = 4;
    localparam int LEN_W    = 16;
    localparam int POLL_MAX = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic             cmd_valid = 0, cmd_write = 0;
    logic [15:0]      cmd_addr = 0;
    logic [LEN_W-1:0] cmd_len = 0;
    logic [7:0]       wr_data = 0;
    logic             wr_valid = 0, rd_ready = 0;
    logic             cmd_ready, wr_ready, rd_valid, busy, done, err_req, err_timeout;
    logic [7:0]       rd_data;
    logic             spi_sck, spi_mosi, spi_cs_n;
    logic             spi_miso = 1'b0;

    spi_eeprom_seq #(.DIV(DIV), .LEN_W(LEN_W), .PAGE_BYTES(64), .POLL_MAX(POLL_MAX)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .busy(busy), .done(done), .err_req(err_req), .err_timeout(err_timeout),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    int errors = 0, checks = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pattern(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // ---------------- behavioural memory device ----------------
    logic [7:0] dev_mem [int];
    logic [7:0] ref_mem [int];
    logic [7:0] cur [$];
    logic [7:0] flog [$];
    int         flen [$];
    logic [7:0] in_sh, out_sh;
    int         nbits, out_idx = 8;
    logic [15:0] s_addr;
    int         wip_left = 0, busy_setting = 0;

    function automatic logic [7:0] dev_rd(input logic [15:0] a);
        return dev_mem.exists(int'(a)) ? dev_mem[int'(a)] : pattern(a);
    endfunction
    function automatic logic [7:0] ref_rd(input logic [15:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : pattern(a);
    endfunction

    always @(negedge spi_cs_n) begin
        nbits = 0; cur.delete(); out_idx = 8;
    end

    always @(posedge spi_sck) if (spi_cs_n === 1'b0) begin
        in_sh = {in_sh[6:0], spi_mosi};
        nbits++;
        if (nbits % 8 == 0) begin
            cur.push_back(in_sh);
            if (cur.size() == 1 && in_sh == 8'h05) begin
                out_sh = (wip_left > 0) ? 8'h01 : 8'h00; out_idx = 0;
            end else if (cur[0] == 8'h03 && cur.size() >= 3) begin
                if (cur.size() == 3) s_addr = {cur[1], cur[2]};
                out_sh = dev_rd(s_addr); s_addr = s_addr + 16'd1; out_idx = 0;
            end
        end
    end

    always @(negedge spi_sck) if (spi_cs_n === 1'b0 && out_idx < 8) begin
        spi_miso = out_sh[7-out_idx];
        out_idx++;
    end

    always @(posedge spi_cs_n) if (cur.size() > 0) begin
        flen.push_back(cur.size());
        foreach (cur[i]) flog.push_back(cur[i]);
        if (cur[0] == 8'h02 && cur.size() > 3) begin
            logic [15:0] a;
            a = {cur[1], cur[2]};
            for (int i = 3; i < cur.size(); i++) begin
                dev_mem[int'(a)] = cur[i];
                a = {a[15:6], a[5:0] + 6'd1};
            end
            wip_left = busy_setting;
        end else if (cur[0] == 8'h05 && wip_left > 0) begin
            wip_left--;
        end
        cur.delete();
    end

    // ---------------- per-clock bus monitor ----------------
    int viol_idle = 0, viol_period = 0, viol_gap = 0, viol_host = 0;
    int hi_run = 0, cyc_since_rise = 0, rise_in_frame = 0, gap_seen = 0;
    bit prev_sck = 0, prev_cs = 1, seen_frame = 0;

    always @(negedge clk) if (!rst) begin
        if (spi_cs_n && spi_sck) viol_idle++;
        if (busy && cmd_ready) viol_host++;
        cyc_since_rise++;
        if (spi_sck && !prev_sck) begin
            if (rise_in_frame % 8 != 0 && cyc_since_rise != DIV) viol_period++;
            rise_in_frame++;
            cyc_since_rise = 0;
        end
        if (!spi_cs_n && prev_cs) begin
            if (seen_frame) begin
                gap_seen++;
                if (hi_run < 2*DIV) viol_gap++;
            end
            seen_frame = 1; hi_run = 0; rise_in_frame = 0;
        end
        if (spi_cs_n) hi_run++;
        prev_sck = spi_sck; prev_cs = spi_cs_n;
    end

    // ---------------- host driver ----------------
    logic [7:0] wq [$];
    logic [7:0] rq [$];
    bit last_err_req, last_err_to;
    int done_cyc;

    task automatic do_cmd(input bit wr, input logic [15:0] a, input int len, input int stall_mod);
        int cyc = 0;
        bit acc = 0, w_take = 0, seen = 0;
        int widx = 0;
        rq.delete(); flog.delete(); flen.delete();
        @(negedge clk);
        cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_len = LEN_W'(len);
        while (!seen && cyc < 30000) begin
            if (cmd_valid && cmd_ready) acc = 1;
            wr_valid = (widx < wq.size());
            wr_data  = (widx < wq.size()) ? wq[widx] : 8'h00;
            w_take   = wr_valid && wr_ready;
            rd_ready = (stall_mod == 0) || (cyc % stall_mod != 0);
            if (rd_valid && rd_ready) rq.push_back(rd_data);
            if (done) begin
                seen = 1; last_err_req = err_req; last_err_to = err_timeout; done_cyc = cyc;
            end
            @(negedge clk);
            cyc++;
            if (acc) cmd_valid = 0;
            if (w_take) widx++;
        end
        wr_valid = 0; rd_ready = 0; cmd_valid = 0;
        chk(seen, "R9", "request completes", seen, 1);
        chk(!done, "R9", "done lasts one cycle", done, 0);
    endtask

    logic [7:0] eflog [$];
    int         eflen [$];

    task automatic cmp_frames(input string req);
        int bad = 0;
        if (flen.size() != eflen.size()) bad++;
        else foreach (flen[i]) if (flen[i] != eflen[i]) bad++;
        if (flog.size() != eflog.size()) bad++;
        else foreach (flog[i]) if (flog[i] != eflog[i]) bad++;
        chk(bad == 0, req, "frame count/bytes", flen.size(), eflen.size());
    endtask

    task automatic write_test(input logic [15:0] a, input int len, input int bsy, input bit expect_to);
        int polls;
        wq.delete();
        for (int i = 0; i < len; i++) wq.push_back(8'(i * 7 + 3) ^ a[7:0]);
        busy_setting = bsy;
        eflog.delete(); eflen.delete();
        eflen.push_back(1); eflog.push_back(8'h06);
        eflen.push_back(3 + len); eflog.push_back(8'h02); eflog.push_back(a[15:8]); eflog.push_back(a[7:0]);
        foreach (wq[i]) eflog.push_back(wq[i]);
        polls = (bsy + 1 < POLL_MAX) ? bsy + 1 : POLL_MAX;
        for (int i = 0; i < polls; i++) begin eflen.push_back(2); eflog.push_back(8'h05); eflog.push_back(8'h00); end
        begin
            logic [15:0] p;
            p = a;
            foreach (wq[i]) begin ref_mem[int'(p)] = wq[i]; p = {p[15:6], p[5:0] + 6'd1}; end
        end
        do_cmd(1'b1, a, len, 0);
        cmp_frames("R3 R4 R6");
        chk(last_err_req == 0, "R5", "legal write not refused", last_err_req, 0);
        chk(last_err_to == expect_to, "R7", "timeout flag", last_err_to, expect_to);
        wip_left = 0;
    endtask

    task automatic read_test(input logic [15:0] a, input int len, input int stall);
        int bad = 0;
        eflog.delete(); eflen.delete();
        eflen.push_back(3 + len); eflog.push_back(8'h03); eflog.push_back(a[15:8]); eflog.push_back(a[7:0]);
        for (int i = 0; i < len; i++) eflog.push_back(8'h00);
        do_cmd(1'b0, a, len, stall);
        cmp_frames("R8");
        chk(rq.size() == len, "R8", "read byte count", rq.size(), len);
        foreach (rq[i]) if (rq[i] != ref_rd(a + 16'(i))) bad++;
        chk(bad == 0, "R8 R1", "read data vs model", bad, 0);
    endtask

    task automatic reject_test(input bit wr, input logic [15:0] a, input int len);
        wq.delete();
        do_cmd(wr, a, len, 0);
        chk(flen.size() == 0, "R5", "no frame on refusal", flen.size(), 0);
        chk(last_err_req == 1 && done_cyc == 1, "R5", "refusal done+err next cycle", done_cyc, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(cmd_ready && !busy && !done, "R9", "idle after reset", {cmd_ready, busy, done}, 3'b100);
        chk(spi_cs_n && !spi_sck, "R2", "bus idle after reset", {spi_cs_n, spi_sck}, 2'b10);

        write_test(16'h1234, 8, 3, 0);
        read_test(16'h1230, 16, 3);
        write_test(16'h003C, 4, 0, 0);          // offset+count == 64: accepted (R5)
        reject_test(1'b1, 16'h003C, 5);         // R5 crosses page
        reject_test(1'b0, 16'h0400, 0);         // R5 zero count
        write_test(16'h0100, 64, 1, 0);         // full page (R4)
        read_test(16'h00F8, 80, 0);             // read across pages (R8)
        write_test(16'h0200, 2, POLL_MAX - 1, 0); // clear on last allowed poll (R7)
        write_test(16'h0300, 2, POLL_MAX, 1);     // limit reached (R7)
        write_test(16'h0400, 1, 100, 1);          // R7 long busy
        read_test(16'h0200, 2, 2);
        read_test(16'h0000, 64, 4);

        chk(viol_idle == 0, "R2", "SCK low while deselected", viol_idle, 0);
        chk(viol_gap == 0 && gap_seen > 0, "R2", "deselect gap >= 2*DIV", viol_gap, 0);
        chk(viol_period == 0, "R1", "SCK period within byte", viol_period, 0);
        chk(viol_host == 0, "R9", "cmd_ready low while busy", viol_host, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule